// File: doc/BRIEF.md
# Shifted-Operand Adder with Condition Flags

This block is one slice of an execute stage. It takes a first operand and a second operand. It shifts the second operand by an amount held in the low byte of a third register value, then adds the shifted value to the first operand with no carry-in. It can also produce new negative, zero, carry and overflow flags from that sum. The shift is chosen from four kinds: logical left, logical right, arithmetic right and rotate right. Amounts of 32 or more saturate in a way that depends on the kind.

The block also receives the four register indices of the operation: destination, first source, second source and amount source. If any of these indices is 15, the operation is illegal. In that case the block raises an illegal flag and blocks the write and the flag update. Fetch, decode, the register file and the condition evaluator are outside the block. The caller supplies a condition-passed bit and the current flags.

The datapath is combinational. A single register stage captures the sum, the write enable, the next flags and the illegal indication on the rising clock edge. Latency is therefore always exactly one cycle, whatever the data.

Top module: `shadd_flags`

## Requirements
- R1: `shift_kind` selects the shift applied to `op_b`: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. The amount is the unsigned value of `amt_reg[7:0]`, from 0 to 255.
- R2: An amount of 0 leaves `op_b` unchanged for every kind. For amounts of 32 or more, logical shifts give zero and arithmetic right fills every bit with `op_b[31]`. Rotate right always uses the amount modulo 32.
- R3: `result_q` equals `op_a` plus the shifted operand, modulo 2^32, with a carry-in of zero. It is captured on every rising edge, so it is visible one cycle after the inputs.
- R4: The flag vector is ordered {N,Z,C,V} on bits [3:0]. N is sum bit 31. Z is set when the 32-bit sum is zero. C is the carry out of bit 31. V is set when both addends share a sign and the sum's sign differs from it.
- R5: When `set_flags` is 0, `flags_q` takes the value of `flags_in`.
- R6: When `cond_ok` is 0, `wr_en_q` is 0 and `flags_q` takes the value of `flags_in`. When `cond_ok` is 1 and the operation is legal, `wr_en_q` is 1.
- R7: If any of `idx_dst`, `idx_a`, `idx_b` or `idx_amt` equals 15, then `illegal_q` is 1, `wr_en_q` is 0 and `flags_q` takes the value of `flags_in`. Otherwise `illegal_q` is 0.
- R8: `result_q` does not depend on `flags_in` (including its carry bit) or on `amt_reg[31:8]`. Latency is one cycle for all data.
- R9: While `rst` is high at a rising edge, `result_q`, `wr_en_q`, `flags_q` and `illegal_q` all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First addend |
| op_b | input | 32 | Operand to be shifted |
| amt_reg | input | 32 | Register value whose low byte is the shift amount |
| shift_kind | input | 2 | Shift kind select |
| set_flags | input | 1 | Request flag update from the sum |
| cond_ok | input | 1 | Condition check passed |
| idx_dst | input | 4 | Destination register index |
| idx_a | input | 4 | First source register index |
| idx_b | input | 4 | Shifted source register index |
| idx_amt | input | 4 | Amount source register index |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result_q | output | 32 | Registered sum |
| wr_en_q | output | 1 | Registered write enable |
| flags_q | output | 4 | Registered next flags {N,Z,C,V} |
| illegal_q | output | 1 | Registered illegal-index indication |

## Verification
Random operands are driven with all four shift kinds. Amounts are weighted toward the edges 0, 1, 31, 32, 33 and 255 so that each saturation branch is exercised. High junk bits in the amount register and a toggled carry input show that neither affects the sum. Directed additions separate the four flags from one another: signed overflow without carry, carry with a zero sum, and a negative result without either. Random mixes of `cond_ok`, `set_flags` and index values of 15 show which of the three gates blocks the write and the flag update.

// File: rtl/shadd_flags.sv
module shadd_flags #(
  parameter int W  = 32,
  parameter int IW = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  amt_reg,
  input  logic [1:0]    shift_kind,
  input  logic          set_flags,
  input  logic          cond_ok,
  input  logic [IW-1:0] idx_dst,
  input  logic [IW-1:0] idx_a,
  input  logic [IW-1:0] idx_b,
  input  logic [IW-1:0] idx_amt,
  input  logic [3:0]    flags_in,
  output logic [W-1:0]  result_q,
  output logic          wr_en_q,
  output logic [3:0]    flags_q,
  output logic          illegal_q
);
  localparam int SW = $clog2(W);
  localparam logic [IW-1:0] BAD = '1;

  logic [AW-1:0]  amt;
  logic [SW-1:0]  sub;
  logic           big;
  logic [2*W-1:0] rot2;
  logic [W-1:0]   shb;
  logic [W:0]     sum;
  logic [3:0]     nzcv;
  logic           bad;
  logic           upd;
  logic           unused_amt_hi;

  assign amt           = amt_reg[AW-1:0];
  assign unused_amt_hi = ^amt_reg[W-1:AW];
  assign sub           = amt[SW-1:0];
  assign big           = amt >= AW'(W);
  assign rot2          = {op_b, op_b} >> sub;

  always_comb begin
    case (shift_kind)
      2'b00:   shb = big ? '0 : op_b << sub;
      2'b01:   shb = big ? '0 : op_b >> sub;
      2'b10:   shb = big ? {W{op_b[W-1]}} : unsigned'($signed(op_b) >>> sub);
      default: shb = rot2[W-1:0];
    endcase
  end

  assign sum  = {1'b0, op_a} + {1'b0, shb};
  assign nzcv = {sum[W-1], sum[W-1:0] == '0, sum[W],
                 (op_a[W-1] == shb[W-1]) && (sum[W-1] != op_a[W-1])};
  assign bad  = (idx_dst == BAD) || (idx_a == BAD) || (idx_b == BAD) || (idx_amt == BAD);
  assign upd  = cond_ok && !bad && set_flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      wr_en_q   <= 1'b0;
      flags_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      result_q  <= sum[W-1:0];
      wr_en_q   <= cond_ok && !bad;
      flags_q   <= upd ? nzcv : flags_in;
      illegal_q <= bad;
    end
  end

  // R7
  illegal_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_dst == BAD || idx_a == BAD || idx_b == BAD || idx_amt == BAD)
      |=> illegal_q && !wr_en_q && flags_q == $past(flags_in));

  // R6
  cond_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |=> !wr_en_q && flags_q == $past(flags_in));

  // R5
  keep_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> flags_q == $past(flags_in));

  // R4
  nz_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_ok && set_flags && idx_dst != BAD && idx_a != BAD && idx_b != BAD && idx_amt != BAD)
      |=> flags_q[3] == result_q[W-1] && flags_q[2] == (result_q == '0));

  // R2
  zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (amt_reg[AW-1:0] == '0) |=> result_q == $past(op_a + op_b));

endmodule

// File: tb/sim_shadd_flags.sv
module sim_shadd_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0, amt_reg = '0;
  logic [1:0]  shift_kind = '0;
  logic        set_flags = 1'b0, cond_ok = 1'b0;
  logic [3:0]  idx_dst = '0, idx_a = '0, idx_b = '0, idx_amt = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result_q;
  logic        wr_en_q, illegal_q;
  logic [3:0]  flags_q;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  shadd_flags u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .amt_reg(amt_reg),
    .shift_kind(shift_kind), .set_flags(set_flags), .cond_ok(cond_ok),
    .idx_dst(idx_dst), .idx_a(idx_a), .idx_b(idx_b), .idx_amt(idx_amt),
    .flags_in(flags_in), .result_q(result_q), .wr_en_q(wr_en_q),
    .flags_q(flags_q), .illegal_q(illegal_q)
  );

  function automatic logic [31:0] ref_shift(logic [31:0] b, logic [1:0] k, int n);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) begin
      int j;
      case (k)
        2'b00: begin j = i - n; o[i] = (j >= 0) ? b[j] : 1'b0; end
        2'b01: begin j = i + n; o[i] = (j <= 31) ? b[j] : 1'b0; end
        2'b10: begin j = i + n; o[i] = (j <= 31) ? b[j] : b[31]; end
        default: begin j = (i + (n % 32)) % 32; o[i] = b[j]; end
      endcase
    end
    return o;
  endfunction

  function automatic logic [3:0] ref_flags(logic [31:0] a, logic [31:0] s);
    longint unsigned t;
    logic [31:0] r;
    logic n, z, c, v;
    t = longint'(a) + longint'(s);
    r = t[31:0];
    n = r[31];
    z = (r == 32'd0);
    c = t[32];
    v = (a[31] == s[31]) && (r[31] != a[31]);
    return {n, z, c, v};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req);
    logic [31:0] sh, er;
    logic bad;
    logic [3:0] ef;
    sh  = ref_shift(op_b, shift_kind, int'(amt_reg[7:0]));
    er  = op_a + sh;
    bad = (idx_dst == 4'd15) || (idx_a == 4'd15) || (idx_b == 4'd15) || (idx_amt == 4'd15);
    ef  = (cond_ok && !bad && set_flags) ? ref_flags(op_a, sh) : flags_in;
    @(posedge clk); #1;
    chk(req, "result", result_q, er);
    chk(req, "wr_en", {31'd0, wr_en_q}, {31'd0, cond_ok && !bad});
    chk(req, "flags", {28'd0, flags_q}, {28'd0, ef});
    chk(req, "illegal", {31'd0, illegal_q}, {31'd0, bad});
  endtask

  task automatic legal_set();
    idx_dst = 4'd1; idx_a = 4'd2; idx_b = 4'd3; idx_amt = 4'd4;
    cond_ok = 1'b1; set_flags = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1;
    int seed_dummy;
    seed_dummy = $urandom(20240611);
    rst = 1'b1;
    op_a = 32'hdead_beef; op_b = 32'h1234_5678; cond_ok = 1'b1; set_flags = 1'b1;
    flags_in = 4'hf;
    repeat (2) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9", "result", result_q, 32'd0);
    chk("R9", "wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R9", "flags", {28'd0, flags_q}, 32'd0);
    chk("R9", "illegal", {31'd0, illegal_q}, 32'd0);
    rst = 1'b0;

    // R1 R2 each kind at edge amounts
    legal_set();
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 7; e++) begin
        int amts[7] = '{0, 1, 31, 32, 33, 64, 255};
        op_a = 32'h0000_1000; op_b = 32'h8421_00f5;
        shift_kind = k[1:0]; amt_reg = amts[e];
        flags_in = 4'b0010;
        run_op(e == 0 || e >= 3 ? "R2" : "R1");
      end
    end
    // R2 direct values
    legal_set(); op_a = 0; op_b = 32'h8000_0001;
    shift_kind = 2'b10; amt_reg = 32'd40; run_op("R2");
    chk("R2", "asr_fill", result_q, 32'hffff_ffff);
    shift_kind = 2'b11; amt_reg = 32'd33; run_op("R2");
    chk("R2", "ror_mod", result_q, 32'hc000_0000);
    shift_kind = 2'b00; amt_reg = 32'd32; run_op("R2");
    chk("R2", "lsl_sat", result_q, 32'd0);

    // R4 flag corners
    legal_set(); shift_kind = 2'b00; amt_reg = 0; flags_in = 4'b0000;
    op_a = 32'h7fff_ffff; op_b = 32'd1; run_op("R4");
    chk("R4", "ovf_neg", {28'd0, flags_q}, 32'b1001);
    op_a = 32'hffff_ffff; op_b = 32'd1; run_op("R4");
    chk("R4", "zero_carry", {28'd0, flags_q}, 32'b0110);
    op_a = 32'h8000_0000; op_b = 32'h8000_0000; run_op("R4");
    chk("R4", "carry_ovf_zero", {28'd0, flags_q}, 32'b0111);
    op_a = 32'hffff_fff0; op_b = 32'd1; run_op("R4");
    chk("R4", "neg_only", {28'd0, flags_q}, 32'b1000);

    // R5 no set flags, R6 cond off
    legal_set(); set_flags = 1'b0; flags_in = 4'b1010; op_a = 32'hffff_ffff; op_b = 1;
    run_op("R5");
    chk("R5", "kept", {28'd0, flags_q}, 32'b1010);
    legal_set(); cond_ok = 1'b0; flags_in = 4'b0101; run_op("R6");
    chk("R6", "no_wr", {31'd0, wr_en_q}, 32'd0);

    // R7 each index at 15
    for (int p = 0; p < 4; p++) begin
      legal_set(); flags_in = 4'b0011; op_a = 32'hffff_ffff; op_b = 1;
      case (p)
        0: idx_dst = 4'd15;
        1: idx_a = 4'd15;
        2: idx_b = 4'd15;
        default: idx_amt = 4'd15;
      endcase
      run_op("R7");
      chk("R7", "flags_kept", {28'd0, flags_q}, 32'b0011);
    end

    // R8 carry input and upper amount bits have no effect
    legal_set(); op_a = 32'h0102_0304; op_b = 32'hf00f_1234; shift_kind = 2'b11;
    amt_reg = 32'h0000_0007; flags_in = 4'b0000; run_op("R8");
    r0 = result_q;
    amt_reg = 32'habcd_ef07; flags_in = 4'b0010; run_op("R8");
    r1 = result_q;
    chk("R8", "independent", r1, r0);

    // R3 random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      op_a = $urandom; op_b = $urandom;
      shift_kind = 2'($urandom);
      sel = $urandom_range(0, 9);
      case (sel)
        0: amt_reg = {$urandom, 8'd0} >> 8;
        1: amt_reg = 32'd32;
        2: amt_reg = 32'd31;
        3: amt_reg = {24'($urandom), 8'd255};
        default: amt_reg = $urandom;
      endcase
      cond_ok   = ($urandom_range(0, 3) != 0);
      set_flags = $urandom_range(0, 1) != 0;
      flags_in  = 4'($urandom);
      idx_dst = 4'($urandom_range(0, 15));
      idx_a   = 4'($urandom_range(0, 14));
      idx_b   = 4'($urandom_range(0, 14));
      idx_amt = 4'($urandom_range(0, 14));
      run_op("R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule